// File: doc/BRIEF.md
# USB Device Suspend and Remote-Wakeup Controller

This block keeps the power-state control register of a full-speed USB device. It watches the decoded line state (J, K, SE0) and an idle flag from the serial engine. It declares suspend after a long enough idle stretch, and it sees the host's resume signalling (K) while suspended. It also sees a long SE0 as a bus reset. Suspend and resume each raise a status bit. These bits feed one registered interrupt line, and a mask bit can hide the suspend cause.

Software can ask for a remote wakeup while the device is suspended. The block then drives K for a fixed window through a drive-enable and a drive-K request to the transceiver. After the window the block is still suspended, so a resume from the host is then handled in the normal way. Clearing the enable bit resets every piece of state at once and releases the line drive.

Register bits (one 8-bit register): bit 0 enable (RW), bit 1 active (RO), bit 2 wake trigger (write 1 to start; reads 1 while K is driven), bit 3 resume status (write 1 to clear), bit 4 suspend status (write 1 to clear), bit 5 suspend mask (RW), bits 7:6 read 0. Line state encoding: 00 SE0, 01 J, 10 K, 11 illegal.

Top module: `usb_pwr_ctl`

## Requirements
- R1: While enable is 0, every status bit, the active bit, the wake trigger bit, irq, drv_oe and drv_k read 0, and line or idle activity changes none of them. Writing enable to 0 releases drv_oe and drv_k in the cycle after the write, and it clears the status bits one cycle later.
- R2: The active bit reads 1 one cycle after xact_busy is 1 while enabled and no bus reset is seen. It reads 0 while disabled.
- R3: Writing 1 to bit 2 while suspended drives drv_oe=1 and drv_k=1 for exactly WAKE_CYC cycles, starting in the cycle after the write. Bit 2 reads 1 for that time and then returns to 0 by itself.
- R4: When the wake window ends the block is still suspended, so a later K on the line is taken as a resume.
- R5: The suspend status (bit 4) sets after SUSP_CYC consecutive cycles with bus_idle=1. A single cycle with bus_idle=0 restarts the count.
- R6: The suspend status is sticky. A write with bit 4 = 1 clears it, and a write with bit 4 = 0 leaves it unchanged.
- R7: While suspended and not driving, line state K ends suspend. It sets the resume status (bit 3) only if the mask (bit 5) is 0. A write with bit 3 = 1 clears the resume status.
- R8: Writing the mask never changes the suspend status. With mask=1 a set suspend status does not raise irq. With mask=0 it does.
- R9: irq is a register. It is 1 one cycle after (suspend status AND NOT mask) OR resume status becomes true while enabled.
- R10: SE0 held for RST_CYC cycles ends suspend and any wake drive, and it clears the active bit until SE0 ends.
- R11: A wake trigger written while the block is not suspended is ignored. drv_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| line_state | input | 2 | Decoded bus line state: 00 SE0, 01 J, 10 K |
| bus_idle | input | 1 | Serial engine reports an idle bus |
| xact_busy | input | 1 | Serial engine reports a transaction in progress |
| drv_oe | output | 1 | Transceiver drive enable (0 = tri-state) |
| drv_k | output | 1 | Request to drive K on the bus |
| irq | output | 1 | Registered interrupt request |

## Verification
Every result has a fixed latency, and the bench checks both sides of each boundary. Suspend status appears at the SUSP_CYC-th idle edge, and the bench also checks one edge before it. A resume status appears one edge after K. The K drive starts at the write edge and ends exactly WAKE_CYC edges later. The active bit falls at the RST_CYC-th SE0 edge, and irq trails its cause by one more edge. Inputs change and outputs are sampled on the falling clock edge, so each check sits between two known rising edges.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;

   localparam int unsigned REG_W  = 8;
   localparam int unsigned B_EN   = 0;
   localparam int unsigned B_ACT  = 1;
   localparam int unsigned B_WAKE = 2;
   localparam int unsigned B_RES  = 3;
   localparam int unsigned B_SUS  = 4;
   localparam int unsigned B_MASK = 5;

endpackage

// File: rtl/usb_pwr_timer.sv
module usb_pwr_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("usb_pwr_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (run && cnt != LAST)  cnt <= cnt + 1'b1;
   end

   assign expired = run & ~clr & (cnt == LAST);

   assert_expiry_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expired |-> $past(run) && !$past(clr));

endmodule

// File: rtl/usb_pwr_core.sv
module usb_pwr_core
   import usb_pwr_pkg::*;
#(
   parameter int unsigned SUSP_CYC = 288000,
   parameter int unsigned WAKE_CYC = 144000,
   parameter int unsigned RST_CYC  = 120
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  logic  mask,
   input  line_t line,
   input  logic  bus_idle,
   input  logic  xact_busy,
   input  logic  wake_req,
   output logic  susp_set,
   output logic  res_set,
   output logic  suspended,
   output logic  waking,
   output logic  active
);
   logic se0, kst, idle_exp, rst_now, wake_done, resume_seen;

   assign se0 = (line == LS_SE0);
   assign kst = (line == LS_K);

   usb_pwr_timer #(.LIMIT(SUSP_CYC)) u_idle_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr(~en | ~bus_idle | suspended),
      .run(en & bus_idle & ~suspended),
      .expired(idle_exp));

   usb_pwr_timer #(.LIMIT(RST_CYC)) u_rst_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr(~en | ~se0),
      .run(en & se0),
      .expired(rst_now));

   usb_pwr_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr(~waking),
      .run(waking),
      .expired(wake_done));

   assign resume_seen = en & suspended & ~waking & kst & ~rst_now;
   assign susp_set    = idle_exp;
   assign res_set     = resume_seen & ~mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         suspended <= 1'b0;
         waking    <= 1'b0;
         active    <= 1'b0;
      end else if (!en) begin
         suspended <= 1'b0;
         waking    <= 1'b0;
         active    <= 1'b0;
      end else begin
         active <= xact_busy & ~rst_now;
         if (rst_now)          suspended <= 1'b0;
         else if (idle_exp)    suspended <= 1'b1;
         else if (resume_seen) suspended <= 1'b0;
         if (rst_now)                                  waking <= 1'b0;
         else if (waking && wake_done)                 waking <= 1'b0;
         else if (wake_req && suspended && !waking)    waking <= 1'b1;
      end
   end

   assert_wake_only_suspended_R3: assert property (@(posedge clk) disable iff (!rst_n)
      waking |-> suspended);

   assert_reset_leaves_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_now |=> !suspended && !waking && !active);

   assert_wake_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req && !suspended && !waking |=> !waking);

endmodule

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl
   import usb_pwr_pkg::*;
#(
   parameter int unsigned SUSP_CYC = 288000,
   parameter int unsigned WAKE_CYC = 144000,
   parameter int unsigned RST_CYC  = 120
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic [1:0]       line_state,
   input  logic             bus_idle,
   input  logic             xact_busy,
   output logic             drv_oe,
   output logic             drv_k,
   output logic             irq
);
   generate
      if (WAKE_CYC < 2 || SUSP_CYC < 2 || RST_CYC < 2) begin : g_bad_cfg
         $error("usb_pwr_ctl: all interval parameters must be at least 2");
      end
   endgenerate

   logic en_q, mask_q, sus_sts, res_sts;
   logic susp_set, res_set, suspended, waking, active;
   logic wake_req, clr_sus, clr_res;
   logic unused_wbits;

   assign unused_wbits = ^{cfg_wdata[7:6], cfg_wdata[B_ACT]};
   assign wake_req = cfg_wr & cfg_wdata[B_WAKE];
   assign clr_sus  = cfg_wr & cfg_wdata[B_SUS];
   assign clr_res  = cfg_wr & cfg_wdata[B_RES];

   usb_pwr_core #(.SUSP_CYC(SUSP_CYC), .WAKE_CYC(WAKE_CYC), .RST_CYC(RST_CYC)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en_q), .mask(mask_q),
      .line(line_t'(line_state)), .bus_idle(bus_idle), .xact_busy(xact_busy),
      .wake_req(wake_req), .susp_set(susp_set), .res_set(res_set),
      .suspended(suspended), .waking(waking), .active(active));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mask_q  <= 1'b0;
         sus_sts <= 1'b0;
         res_sts <= 1'b0;
         irq     <= 1'b0;
      end else begin
         if (cfg_wr) begin
            en_q   <= cfg_wdata[B_EN];
            mask_q <= cfg_wdata[B_MASK];
         end
         if (!en_q) begin
            sus_sts <= 1'b0;
            res_sts <= 1'b0;
         end else begin
            sus_sts <= susp_set | (sus_sts & ~clr_sus);
            res_sts <= res_set  | (res_sts & ~clr_res);
         end
         irq <= en_q & ((sus_sts & ~mask_q) | res_sts);
      end
   end

   assign drv_oe = waking & en_q;
   assign drv_k  = waking & en_q;

   always_comb begin
      cfg_rdata         = '0;
      cfg_rdata[B_EN]   = en_q;
      cfg_rdata[B_ACT]  = active;
      cfg_rdata[B_WAKE] = waking;
      cfg_rdata[B_RES]  = res_sts;
      cfg_rdata[B_SUS]  = sus_sts;
      cfg_rdata[B_MASK] = mask_q;
   end

   assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !sus_sts && !res_sts && !active && !waking);

   assert_sus_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && sus_sts && !clr_sus |=> sus_sts);

   assert_mask_hides_sus_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q && !res_sts |=> !irq);

   assert_irq_follows_res_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && res_sts |=> irq);

   assert_drive_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drv_k |-> drv_oe);

endmodule

// File: tb/usb_pwr_ctl_tb.sv
module usb_pwr_ctl_tb;
   localparam int unsigned SUSP = 40;
   localparam int unsigned WAKE = 20;
   localparam int unsigned RSTC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic [1:0] line_state = 2'b01;
   logic bus_idle = 1'b0;
   logic xact_busy = 1'b0;
   logic drv_oe, drv_k, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   usb_pwr_ctl #(.SUSP_CYC(SUSP), .WAKE_CYC(WAKE), .RST_CYC(RSTC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .line_state(line_state), .bus_idle(bus_idle),
      .xact_busy(xact_busy), .drv_oe(drv_oe), .drv_k(drv_k), .irq(irq));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = 8'h00;
   endtask

   task automatic reach_suspend();
      bus_idle = 1'b1;
      tick(SUSP);
      bus_idle = 1'b0;
   endtask

   task automatic t_reset_state();
      check("R1 reset register", cfg_rdata, 8'h00);
      check("R1 reset outputs", {5'd0, drv_oe, drv_k, irq}, 8'h00);
      wr(8'h01);
      check("R1 enable readback", cfg_rdata, 8'h01);
   endtask

   task automatic t_idle_restart();
      bus_idle = 1'b1; tick(SUSP - 1);
      bus_idle = 1'b0; tick(1);
      bus_idle = 1'b1; tick(SUSP - 1);
      check("R5 no suspend before limit after restart", {7'd0, cfg_rdata[4]}, 8'h00);
      tick(1);
      check("R5 suspend status at limit", {7'd0, cfg_rdata[4]}, 8'h01);
      check("R9 irq still low same cycle", {7'd0, irq}, 8'h00);
      tick(1);
      check("R9 irq one cycle later", {7'd0, irq}, 8'h01);
      bus_idle = 1'b0;
   endtask

   task automatic t_mask();
      wr(8'h21);
      check("R8 mask write keeps suspend status", {7'd0, cfg_rdata[4]}, 8'h01);
      tick(1);
      check("R8 masked suspend gives no irq", {7'd0, irq}, 8'h00);
      wr(8'h01);
      tick(1);
      check("R8 unmasked suspend gives irq", {7'd0, irq}, 8'h01);
   endtask

   task automatic t_sticky();
      wr(8'h01);
      check("R6 write 0 keeps status", {7'd0, cfg_rdata[4]}, 8'h01);
      wr(8'h11);
      check("R6 write 1 clears status", {7'd0, cfg_rdata[4]}, 8'h00);
      tick(2);
      check("R9 irq drops after clear", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_wake();
      wr(8'h05);
      check("R3 K drive starts", {6'd0, drv_oe, drv_k}, 8'h03);
      check("R3 trigger reads 1 while driving", {7'd0, cfg_rdata[2]}, 8'h01);
      tick(WAKE - 1);
      check("R3 K drive held to last cycle", {6'd0, drv_oe, drv_k}, 8'h03);
      tick(1);
      check("R3 K drive released", {6'd0, drv_oe, drv_k}, 8'h00);
      check("R3 trigger self-clears", {7'd0, cfg_rdata[2]}, 8'h00);
      tick(2);
      line_state = 2'b10; tick(1);
      check("R4 still suspended: K gives resume status", {7'd0, cfg_rdata[3]}, 8'h01);
      line_state = 2'b01; tick(1);
      check("R9 irq from resume", {7'd0, irq}, 8'h01);
      wr(8'h09);
      check("R7 resume status cleared by write 1", {7'd0, cfg_rdata[3]}, 8'h00);
   endtask

   task automatic t_wake_ignored();
      wr(8'h05);
      check("R11 trigger ignored when awake", {6'd0, drv_oe, cfg_rdata[2]}, 8'h00);
      tick(3);
      check("R11 still no drive", {6'd0, drv_oe, drv_k}, 8'h00);
   endtask

   task automatic t_resume_masked();
      wr(8'h21);
      reach_suspend();
      check("R5 suspend status set", {7'd0, cfg_rdata[4]}, 8'h01);
      line_state = 2'b10; tick(1);
      line_state = 2'b01;
      check("R7 masked resume sets no status", {7'd0, cfg_rdata[3]}, 8'h00);
      wr(8'h25);
      check("R7 resume left suspend, trigger ignored", {7'd0, drv_oe}, 8'h00);
      wr(8'h11);
      check("R6 clear with unmask", cfg_rdata, 8'h01);
   endtask

   task automatic t_usb_reset();
      xact_busy = 1'b1; tick(1);
      check("R2 active while busy", {7'd0, cfg_rdata[1]}, 8'h01);
      reach_suspend();
      wr(8'h11);
      line_state = 2'b00; tick(RSTC - 1);
      check("R10 active before reset limit", {7'd0, cfg_rdata[1]}, 8'h01);
      tick(1);
      check("R10 active cleared by bus reset", {7'd0, cfg_rdata[1]}, 8'h00);
      line_state = 2'b01; tick(1);
      check("R2 active back after reset", {7'd0, cfg_rdata[1]}, 8'h01);
      wr(8'h05);
      check("R10 reset left suspend", {7'd0, drv_oe}, 8'h00);
      xact_busy = 1'b0; tick(1);
      check("R2 active low when idle", {7'd0, cfg_rdata[1]}, 8'h00);
   endtask

   task automatic t_disable();
      reach_suspend();
      wr(8'h05);
      check("R3 drive before disable", {7'd0, drv_oe}, 8'h01);
      wr(8'h00);
      check("R1 drive released by disable", {6'd0, drv_oe, drv_k}, 8'h00);
      tick(1);
      check("R1 register cleared", cfg_rdata, 8'h00);
      check("R1 irq cleared", {7'd0, irq}, 8'h00);
      bus_idle = 1'b1; line_state = 2'b10;
      tick(SUSP + 5);
      check("R1 bus ignored while disabled", cfg_rdata, 8'h00);
      check("R1 outputs quiet while disabled", {5'd0, drv_oe, drv_k, irq}, 8'h00);
      bus_idle = 1'b0; line_state = 2'b01;
      wr(8'h01);
      check("R1 clean state on re-enable", cfg_rdata, 8'h01);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset_state();
      t_idle_restart();
      t_mask();
      t_sticky();
      t_wake();
      t_wake_ignored();
      t_resume_masked();
      t_usb_reset();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule